// File: doc/BRIEF.md
# SPI Slave Port with Chip-Select Error Recovery

This block is the target side of a four-wire serial link. It watches an external serial clock, a data-in line and an active-low select. All three pass through synchronisers into the system clock domain, and the block detects their edges there. Bits arriving on the data line are assembled into bytes and pushed into a receive queue. Bytes that local logic writes into a transmit queue are shifted out on the data-out line. Clock idle level, capture edge and bit order can be configured, so the block pairs with any of the four usual SPI modes.

If the select is released partway through a byte, the block flags an error and raises a one-cycle interrupt. A mode input then chooses what happens next. In the first mode the partial byte is kept, and the remaining bits are taken once the select returns. In the second mode the bit count is dropped and the port stays halted until the enable input is lowered. Further inputs set the data-out enable, the fill used when the transmit queue runs dry, the policy when the receive queue is full, and an interrupt on every select transition while continuous mode is set. The system clock must run at least four times faster than the serial clock.

Top module: `spi_slave_cse`

## Requirements
- R1: After reset, `rx_empty` is 1, `tx_full` is 0, `miso_oe` is 0 and `cs_err_flag` is 0.
- R2: With `cfg_cpol`=0 the serial clock idles low and its leading edge is the rising one; with 1 it idles high and its leading edge is the falling one. With `cfg_cpha`=0, data is captured on the leading edge, and the first outgoing bit is valid on `miso_o` as soon as the select is asserted. With `cfg_cpha`=1, `miso_o` changes on the leading edge and data is captured on the trailing edge.
- R3: With `cfg_lsb_first`=1, bit 0 of each byte travels first in both directions. With 0, bit 7 travels first.
- R4: Each group of 8 captured bits is pushed into the receive queue as one byte. `rx_data` shows the oldest byte, and a one-cycle `rx_rd` pulse removes it.
- R5: Transmit bytes leave in the order they were written. When the transmit queue is empty at the start of a byte, the byte sent is 0x00 if `cfg_tx_zero`=1. If `cfg_tx_zero`=0, every bit of the byte sent equals the last bit sent.
- R6: When a byte completes while the receive queue is full, `cfg_rx_keep`=0 drops the new byte. `cfg_rx_keep`=1 drops the oldest stored byte and stores the new one.
- R7: Releasing the select after 1 to 7 bits of a byte sets the sticky `cs_err_flag` and gives a single-cycle `irq_cs_err` pulse. Releasing it on a byte boundary raises neither.
- R8: With `cfg_err_rst_mode`=0, a select error keeps the partial bit count and the outgoing shift state. The rest of the byte is received and sent after the select returns.
- R9: With `cfg_err_rst_mode`=1, a select error clears the bit count and halts the port. While halted, no byte is received and `miso_oe` stays 0, until `cfg_en` is lowered.
- R10: While `cfg_en` is 0, the bit count, the halt state and `cs_err_flag` are held cleared. The queue contents are kept.
- R11: `miso_oe` is 1 only while enabled, selected, not halted and `cfg_miso_en`=1. `miso_o` is 0 whenever `miso_oe` is 0. Reception does not depend on `cfg_miso_en`.
- R12: With `cfg_cont`=1 and `cfg_cs_irq_en`=1, each select assertion and each release gives one `irq_cs_edge` pulse. With `cfg_cont`=0, none is given.
- R13: `tx_full` is 1 when the transmit queue holds `TX_DEPTH` bytes, and a write while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Port enable; 0 clears engine state |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| cfg_miso_en | input | 1 | Allow driving the data-out line |
| cfg_cont | input | 1 | Continuous transfer mode |
| cfg_cs_irq_en | input | 1 | Select-transition interrupt enable (continuous mode) |
| cfg_err_rst_mode | input | 1 | 0: resume partial byte, 1: clear count and halt |
| cfg_tx_zero | input | 1 | Underflow fill: 1 zeros, 0 repeat last bit |
| cfg_rx_keep | input | 1 | Full receive queue: 1 overwrite oldest, 0 drop new |
| sclk_i | input | 1 | Serial clock from the controller |
| mosi_i | input | 1 | Serial data from the controller |
| cs_n_i | input | 1 | Active-low select |
| miso_o | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | Output enable for `miso_o` |
| tx_wr | input | 1 | Write strobe into the transmit queue |
| tx_data | input | FRAME_W | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Remove the oldest received byte |
| rx_data | output | FRAME_W | Oldest received byte |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| cs_err_flag | output | 1 | Sticky select-error flag |
| irq_cs_err | output | 1 | One-cycle pulse on a select error |
| irq_cs_edge | output | 1 | One-cycle pulse on a select transition |

## Verification
The main data path is exercised in three of the four clock-mode combinations and in both bit orders. The byte values are asymmetric, so a swapped edge, a mirrored shift or a one-bit skew each give a distinct wrong value. Select errors are caused after three bits in each error mode: byte-level continuity on both data lines separates resume from restart, and a byte-boundary release shows that errors are raised only mid-byte. Queue pressure is applied by sending five bytes into a four-deep receive queue under each overflow policy, and by draining the transmit queue into underflow under each fill policy. The oldest and newest bytes then show which one was dropped.

// File: rtl/spis_pkg.sv
// Shared types and helpers for the SPI slave port.
// Assumes byte-sized frames are the common case but keeps widths generic.
package spis_pkg;

    // Static transfer mode, held stable while a transfer is in flight.
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
        logic cont;
        logic cs_irq_en;
        logic err_rst;
        logic tx_zero;
    } spis_mode_t;

    // Index of the synchronised lines inside the sync vector.
    localparam int SY_SCLK = 0;
    localparam int SY_MOSI = 1;
    localparam int SY_CSN  = 2;
    localparam int SY_N    = 3;

endpackage

// File: rtl/spis_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency needed).
module spis_sync #(
    parameter int             N      = 3,
    parameter int             STAGES = 2,
    parameter logic [N-1:0]   RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the raw input through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_V[g]}};
            else        chain <= {chain[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spis_fifo.sv
// Show-ahead queue with a selectable full-queue policy.
// Assumes push and pop are single-cycle strobes; keep=1 overwrites oldest.
module spis_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    input  logic         keep,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == CFULL);
    assign rdata = mem[rp];

    // Decide which pointers move this cycle.
    always_comb begin
        do_rd = (pop && !empty) || (push && full && keep && !pop);
        do_wr = push && (!full || keep || pop);
    end

    // Store the incoming word.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == PLAST) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == PLAST) ? '0 : rp + 1'b1;
            if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
            else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/spis_engine.sv
// Bit engine: edge detection, shift registers, bit count and select-error
// handling. Assumes synchronised inputs and clk at least 4x the serial clock.
module spis_engine
    import spis_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  spis_mode_t   mode,
    input  logic         miso_en,
    input  logic         sclk_s,
    input  logic         mosi_s,
    input  logic         csn_s,
    input  logic [W-1:0] tx_byte,
    input  logic         tx_empty,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_byte,
    output logic         miso_bit,
    output logic         miso_drv,
    output logic         halted,
    output logic         err_flag,
    output logic         err_pulse,
    output logic         edge_pulse
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          sclk_q, csn_q;
    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  rx_sh, tx_sh;
    logic          loaded, last_bit;
    logic          rise, fall, lead, trail, smp_e, shf_e;
    logic          cs_on, cs_off, cs_act, run;
    logic          err_now, load_now, smp_now, shf_now;
    logic [W-1:0]  fill, rx_next, tx_next;

    // Edge classification of the synchronised serial clock and select.
    always_comb begin
        rise   = sclk_s & ~sclk_q;
        fall   = ~sclk_s & sclk_q;
        lead   = mode.cpol ? fall : rise;
        trail  = mode.cpol ? rise : fall;
        smp_e  = mode.cpha ? trail : lead;
        shf_e  = mode.cpha ? lead : trail;
        cs_act = ~csn_s;
        cs_on  = csn_q & ~csn_s;
        cs_off = ~csn_q & csn_s;
        run    = en & cs_act & ~halted;
    end

    // Per-cycle actions of the bit engine.
    always_comb begin
        err_now  = en & cs_off & ~halted & (bit_cnt != '0);
        smp_now  = run & smp_e;
        shf_now  = run & shf_e & ~smp_e;
        load_now = run & (bit_cnt == '0) &
                   ((cs_on & ~mode.cpha & ~loaded) | shf_now);
        fill     = tx_empty ? (mode.tx_zero ? '0 : {W{last_bit}}) : tx_byte;
        rx_next  = mode.lsb_first ? {mosi_s, rx_sh[W-1:1]} : {rx_sh[W-2:0], mosi_s};
        tx_next  = mode.lsb_first ? {1'b0, tx_sh[W-1:1]} : {tx_sh[W-2:0], 1'b0};
        miso_bit = mode.lsb_first ? tx_sh[0] : tx_sh[W-1];
    end

    assign tx_pop   = load_now & ~tx_empty;
    assign rx_push  = smp_now & (bit_cnt == LAST);
    assign rx_byte  = rx_next;
    assign miso_drv = run & miso_en;

    // Remember previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    // Shift, count and select-error state; held clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            loaded    <= 1'b0;
            last_bit  <= 1'b0;
            halted    <= 1'b0;
            err_flag  <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= err_now;
            if (err_now) begin
                err_flag <= 1'b1;
                if (mode.err_rst) begin
                    bit_cnt <= '0;
                    halted  <= 1'b1;
                    loaded  <= 1'b0;
                end
            end else if (smp_now) begin
                rx_sh    <= rx_next;
                bit_cnt  <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
                last_bit <= miso_bit;
                loaded   <= 1'b0;
            end else if (load_now) begin
                tx_sh  <= fill;
                loaded <= 1'b1;
            end else if (shf_now) begin
                tx_sh <= tx_next;
            end
        end
    end

    // Select-transition interrupt in continuous mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) edge_pulse <= 1'b0;
        else edge_pulse <= mode.cont & mode.cs_irq_en & (cs_on | cs_off);
    end
endmodule

// File: rtl/spi_slave_cse.sv
// SPI slave port top: synchronisers, transmit/receive queues, bit engine.
// Assumes clk runs at least 4x the serial clock and inputs are asynchronous.
module spi_slave_cse
    import spis_pkg::*;
#(
    parameter int FRAME_W     = 8,
    parameter int RX_DEPTH    = 4,
    parameter int TX_DEPTH    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_cpol,
    input  logic               cfg_cpha,
    input  logic               cfg_lsb_first,
    input  logic               cfg_miso_en,
    input  logic               cfg_cont,
    input  logic               cfg_cs_irq_en,
    input  logic               cfg_err_rst_mode,
    input  logic               cfg_tx_zero,
    input  logic               cfg_rx_keep,
    input  logic               sclk_i,
    input  logic               mosi_i,
    input  logic               cs_n_i,
    output logic               miso_o,
    output logic               miso_oe,
    input  logic               tx_wr,
    input  logic [FRAME_W-1:0] tx_data,
    output logic               tx_full,
    input  logic               rx_rd,
    output logic [FRAME_W-1:0] rx_data,
    output logic               rx_empty,
    output logic               rx_full,
    output logic               cs_err_flag,
    output logic               irq_cs_err,
    output logic               irq_cs_edge
);
    localparam logic [SY_N-1:0] SYNC_RST = SY_N'(1) << SY_CSN;

    spis_mode_t         mode;
    logic [SY_N-1:0]    raw_v, syn_v;
    logic [FRAME_W-1:0] tx_head, rx_byte;
    logic               tx_empty, tx_pop, rx_push;
    logic               miso_bit, miso_drv, eng_halt;

    // Gather the static mode inputs.
    always_comb begin
        mode.cpol      = cfg_cpol;
        mode.cpha      = cfg_cpha;
        mode.lsb_first = cfg_lsb_first;
        mode.cont      = cfg_cont;
        mode.cs_irq_en = cfg_cs_irq_en;
        mode.err_rst   = cfg_err_rst_mode;
        mode.tx_zero   = cfg_tx_zero;
    end

    assign raw_v[SY_SCLK] = sclk_i;
    assign raw_v[SY_MOSI] = mosi_i;
    assign raw_v[SY_CSN]  = cs_n_i;

    spis_sync #(.N(SY_N), .STAGES(SYNC_STAGES), .RST_V(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_v), .q_o(syn_v)
    );

    spis_fifo #(.W(FRAME_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_data),
        .pop(tx_pop), .keep(1'b0), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    spis_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
        .pop(rx_rd), .keep(cfg_rx_keep), .rdata(rx_data),
        .empty(rx_empty), .full(rx_full)
    );

    spis_engine #(.W(FRAME_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .mode(mode),
        .miso_en(cfg_miso_en),
        .sclk_s(syn_v[SY_SCLK]), .mosi_s(syn_v[SY_MOSI]), .csn_s(syn_v[SY_CSN]),
        .tx_byte(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .miso_bit(miso_bit), .miso_drv(miso_drv), .halted(eng_halt),
        .err_flag(cs_err_flag), .err_pulse(irq_cs_err), .edge_pulse(irq_cs_edge)
    );

    assign miso_oe = miso_drv;
    assign miso_o  = miso_drv & miso_bit;
endmodule

// File: rtl/spi_slave_cse_chk.sv
// Property checker for the SPI slave port, bound to the top module.
// Assumes the synchronous active-low reset of the design.
module spi_slave_cse_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic cfg_cont,
    input logic cfg_cs_irq_en,
    input logic cfg_err_rst_mode,
    input logic cs_err_flag,
    input logic irq_cs_err,
    input logic irq_cs_edge,
    input logic eng_halt
);
    // R7: error interrupt is a single-cycle pulse
    p_err_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cs_err |=> !irq_cs_err);

    // R7: error pulse comes with the sticky flag
    p_err_pulse_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cs_err |-> cs_err_flag);

    // R7: flag stays set while enabled
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_err_flag && cfg_en) |=> cs_err_flag);

    // R10: disabling clears the flag and the halt state
    p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!cs_err_flag && !eng_halt));

    // R9: halting only happens in reset mode
    p_halt_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_halt) |-> $past(cfg_err_rst_mode));

    // R9: halt persists until disable
    p_halt_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_halt && cfg_en) |=> eng_halt);

    // R12: select-transition interrupt only in continuous mode with enable
    p_edge_irq_cont_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cs_edge |-> $past(cfg_cont && cfg_cs_irq_en));
endmodule

bind spi_slave_cse spi_slave_cse_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cont(cfg_cont),
    .cfg_cs_irq_en(cfg_cs_irq_en), .cfg_err_rst_mode(cfg_err_rst_mode),
    .cs_err_flag(cs_err_flag), .irq_cs_err(irq_cs_err),
    .irq_cs_edge(irq_cs_edge), .eng_halt(eng_halt)
);

// File: tb/spi_slave_cse_test.sv
// Scoreboard bench: the driver queues expected receive bytes, a monitor
// pops and compares them as they appear at the receive queue.
module spi_slave_cse_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;

    logic clk = 0, rst_n = 0;
    logic cfg_en = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_miso_en = 1;
    logic cfg_cont = 0, cfg_cs_irq_en = 0, cfg_err_rst_mode = 0, cfg_tx_zero = 0, cfg_rx_keep = 0;
    logic sclk_i = 0, mosi_i = 0, cs_n_i = 1;
    logic miso_o, miso_oe, tx_full, rx_empty, rx_full, cs_err_flag, irq_cs_err, irq_cs_edge;
    logic tx_wr = 0, rx_rd = 0;
    logic [7:0] tx_data = 0, rx_data;

    int n_chk = 0, n_fail = 0, err_cnt = 0, edge_cnt = 0;
    bit done = 0, mon_on = 1;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_slave_cse uut (.*);

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop each received byte and compare with the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rx_rd) rx_rd = 0;
            else if (mon_on && !rx_empty) begin
                if (exp_q.size() == 0) check(0, "R4 unexpected byte", rx_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_data === e, "R4 rx byte", rx_data, e);
                end
                rx_rd = 1;
            end
        end
    end

    // Pulse counters for the interrupts.
    initial begin
        forever begin
            @(negedge clk);
            if (irq_cs_err)  err_cnt++;
            if (irq_cs_edge) edge_cnt++;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_wr = 1;
        @(negedge clk); tx_wr = 0;
    endtask

    task automatic cs_set(input logic v);
        cs_n_i = v;
        wait_clk(HALF);
    endtask

    task automatic restart(input logic cpol, input logic cpha, input logic lsb);
        cfg_en = 0; wait_clk(2);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
        sclk_i = cpol; wait_clk(4);
        cfg_en = 1; wait_clk(2);
        err_cnt = 0; edge_cnt = 0;
    endtask

    // Clock transmission positions first..last of one byte.
    task automatic xfer(input logic [7:0] mo, input logic [7:0] mi, input bit chk,
                        input int first, input int last, input string rq);
        for (int p = first; p <= last; p++) begin
            int idx;
            idx = cfg_lsb_first ? p : 7 - p;
            if (!cfg_cpha) begin
                mosi_i = mo[idx]; wait_clk(HALF);
                if (chk) check(miso_o === mi[idx], rq, miso_o, mi[idx]);
                sclk_i = ~cfg_cpol; wait_clk(HALF);
                sclk_i = cfg_cpol;
            end else begin
                sclk_i = ~cfg_cpol; mosi_i = mo[idx]; wait_clk(HALF);
                if (chk) check(miso_o === mi[idx], rq, miso_o, mi[idx]);
                sclk_i = cfg_cpol; wait_clk(HALF);
            end
        end
        wait_clk(HALF);
    endtask

    task automatic full_byte(input logic [7:0] mo, input logic [7:0] mi, input bit chk,
                             input string rq);
        exp_q.push_back(mo);
        xfer(mo, mi, chk, 0, 7, rq);
    endtask

    task automatic drain_check(input string rq);
        wait_clk(12);
        check(exp_q.size() == 0, rq, exp_q.size(), 0);
    endtask

    task automatic read_rx(input logic [7:0] e, input string rq);
        @(negedge clk);
        check(rx_data === e && !rx_empty, rq, rx_data, e);
        rx_rd = 1; @(negedge clk); rx_rd = 0;
    endtask

    initial begin
        wait_clk(4); rst_n = 1; wait_clk(2);
        // R1 reset state
        check(rx_empty === 1 && tx_full === 0, "R1 queues", {rx_empty, tx_full}, 2'b10);
        check(miso_oe === 0 && cs_err_flag === 0, "R1 oe/flag", {miso_oe, cs_err_flag}, 0);

        // R2/R4/R5 mode 0, msb first, two bytes in one select
        restart(0, 0, 0);
        push_tx(8'hA5); push_tx(8'h3C);
        cs_set(0);
        check(miso_oe === 1, "R11 oe when selected", miso_oe, 1);
        full_byte(8'h5A, 8'hA5, 1, "R2 miso mode0");
        full_byte(8'hC3, 8'h3C, 1, "R5 tx order");
        cs_set(1);
        check(cs_err_flag === 0 && err_cnt == 0, "R7 boundary release", err_cnt, 0);
        check(miso_oe === 0, "R11 oe released", miso_oe, 0);
        drain_check("R4 all received");

        // R3 lsb first
        restart(0, 0, 1);
        push_tx(8'h1E);
        cs_set(0); full_byte(8'h8D, 8'h1E, 1, "R3 lsb first"); cs_set(1);
        drain_check("R3 rx lsb first");

        // R2 cpol=1 cpha=1 and cpol=0 cpha=1
        restart(1, 1, 0);
        push_tx(8'h96);
        cs_set(0); full_byte(8'h4B, 8'h96, 1, "R2 mode3"); cs_set(1);
        drain_check("R2 rx mode3");
        restart(0, 1, 0);
        push_tx(8'h3A);
        cs_set(0); full_byte(8'hE7, 8'h3A, 1, "R2 mode1"); cs_set(1);
        drain_check("R2 rx mode1");

        // R5 underflow repeat last bit, then zeros
        cfg_tx_zero = 0; restart(0, 0, 0);
        push_tx(8'h01);
        cs_set(0); full_byte(8'h10, 8'h01, 1, "R5 pre"); full_byte(8'h20, 8'hFF, 1, "R5 repeat fill"); cs_set(1);
        drain_check("R5 rx");
        cfg_tx_zero = 1; restart(0, 0, 0);
        push_tx(8'h01);
        cs_set(0); full_byte(8'h30, 8'h01, 1, "R5 pre"); full_byte(8'h40, 8'h00, 1, "R5 zero fill"); cs_set(1);
        drain_check("R5 rx zero");

        // R8 resume after select error
        cfg_err_rst_mode = 0; restart(0, 0, 0);
        push_tx(8'hC5);
        cs_set(0);
        exp_q.push_back(8'hB2);
        xfer(8'hB2, 8'hC5, 1, 0, 2, "R8 first part");
        cs_set(1);
        check(cs_err_flag === 1 && err_cnt == 1, "R7 error raised", err_cnt, 1);
        cs_set(0);
        xfer(8'hB2, 8'hC5, 1, 3, 7, "R8 resumed miso");
        cs_set(1);
        check(err_cnt == 1 && cs_err_flag === 1, "R7 flag sticky, single pulse", err_cnt, 1);
        drain_check("R8 resumed byte");

        // R9 halt after select error, R10 clear by disable
        cfg_err_rst_mode = 1; restart(0, 0, 0);
        push_tx(8'hA5);
        cs_set(0); xfer(8'h77, 8'hA5, 0, 0, 2, "R9"); cs_set(1);
        check(cs_err_flag === 1 && err_cnt == 1, "R9 error", err_cnt, 1);
        cs_set(0);
        check(miso_oe === 0, "R9 oe halted", miso_oe, 0);
        xfer(8'h99, 8'h00, 0, 0, 7, "R9"); cs_set(1);
        check(rx_empty === 1 && err_cnt == 1, "R9 nothing received", rx_empty, 1);
        cfg_en = 0; wait_clk(3);
        check(cs_err_flag === 0, "R10 flag cleared", cs_err_flag, 0);
        restart(0, 0, 0);
        push_tx(8'h5A);
        cs_set(0); full_byte(8'h99, 8'h5A, 1, "R10 works after re-enable"); cs_set(1);
        drain_check("R10 rx after re-enable");

        // R11 data-out disabled, reception still works
        cfg_err_rst_mode = 0; cfg_miso_en = 0; restart(0, 0, 0);
        push_tx(8'h55);
        cs_set(0);
        check(miso_oe === 0 && miso_o === 0, "R11 oe off", {miso_oe, miso_o}, 0);
        full_byte(8'h6C, 8'h00, 0, "R11"); cs_set(1);
        drain_check("R11 rx with oe off");
        cfg_miso_en = 1;

        // R12 select-edge interrupt
        cfg_cont = 1; cfg_cs_irq_en = 1; restart(0, 0, 0);
        cs_set(0); full_byte(8'h12, 8'h00, 0, "R12"); cs_set(1);
        check(edge_cnt == 2, "R12 two edge pulses", edge_cnt, 2);
        drain_check("R12 rx");
        cfg_cont = 0; restart(0, 0, 0);
        cs_set(0); full_byte(8'h34, 8'h00, 0, "R12"); cs_set(1);
        check(edge_cnt == 0, "R12 none without continuous", edge_cnt, 0);
        drain_check("R12 rx");
        cfg_cs_irq_en = 0;

        // R13 tx full, R6 discard policy
        cfg_tx_zero = 1; cfg_rx_keep = 0; cfg_en = 0; wait_clk(2);
        push_tx(8'hD1); push_tx(8'hD2); push_tx(8'hD3); push_tx(8'hD4);
        check(tx_full === 1, "R13 full at depth", tx_full, 1);
        push_tx(8'hEE);
        restart(0, 0, 0);
        mon_on = 0; wait_clk(2);
        cs_set(0);
        xfer(8'h11, 8'hD1, 1, 0, 7, "R13 order");
        xfer(8'h22, 8'hD2, 1, 0, 7, "R13 order");
        xfer(8'h33, 8'hD3, 1, 0, 7, "R13 order");
        xfer(8'h44, 8'hD4, 1, 0, 7, "R13 order");
        xfer(8'h55, 8'h00, 1, 0, 7, "R13 dropped write");
        cs_set(1);
        check(rx_full === 1, "R6 rx full", rx_full, 1);
        read_rx(8'h11, "R6 discard oldest kept");
        read_rx(8'h22, "R6 discard");
        read_rx(8'h33, "R6 discard");
        read_rx(8'h44, "R6 discard newest dropped");
        wait_clk(1);
        check(rx_empty === 1, "R6 discard empty", rx_empty, 1);

        // R6 overwrite policy
        cfg_rx_keep = 1; restart(0, 0, 0);
        cs_set(0);
        xfer(8'h11, 8'h00, 0, 0, 7, "R6");
        xfer(8'h22, 8'h00, 0, 0, 7, "R6");
        xfer(8'h33, 8'h00, 0, 0, 7, "R6");
        xfer(8'h44, 8'h00, 0, 0, 7, "R6");
        xfer(8'h55, 8'h00, 0, 0, 7, "R6");
        cs_set(1);
        read_rx(8'h22, "R6 overwrite oldest dropped");
        read_rx(8'h33, "R6 overwrite");
        read_rx(8'h44, "R6 overwrite");
        read_rx(8'h55, "R6 overwrite newest kept");
        wait_clk(1);
        check(rx_empty === 1, "R6 overwrite empty", rx_empty, 1);

        wait_clk(10);
        finish_run();
    end
endmodule